// File: doc/BRIEF.md
# Memory-Mapped Parallel Slave Port

This block lets an external master processor trade bytes with local logic over an 8-bit bidirectional bus. The master sees two locations in its memory map: a data location it may read or write, and a read-only status location whose bit 0 is a handshake flag (HS). The three bus control inputs are chip select (active low), a read/write strobe (high for a master read) and a register select that is normally tied to the master's address LSB. The register select matters only for reads: a write reaches the data register whatever the select is.

Bus ownership alternates through a token. After reset the token is with the master, which writes one byte. The local side consumes it, and the token passes to the slave. The local side then loads a reply byte, and the token returns to the master, which reads the reply. The master polls HS after every access and may go on only when HS reads 1. The bus is modelled as an output-enable plus a data-out vector. The control inputs pass through two-flop synchronizers, and an access takes effect on the trailing (rising) edge of chip select.

The controller has four named states. `ST_IDLE` holds the token with the master, with HS=1. `ST_RX` holds a written byte for the local side, with HS=0. `ST_TXWAIT` holds the token with the slave while it waits for a reply byte, with HS=0. `ST_TXRDY` holds a reply for the master, with HS=1 and the interrupt raised. The transitions are these:
- **master-write**: from `ST_IDLE` to `ST_RX`.
- **local-consume**: from `ST_RX` to `ST_TXWAIT`.
- **local-load**: from `ST_TXWAIT` to `ST_TXRDY`.
- **master-read**: from `ST_TXRDY` to `ST_IDLE`.

Top module: `par_slave_port`

## Requirements
- R1: After reset the controller is in ST_IDLE. HS reads 1, the data register holds 0x00, and rx_valid, tx_ready and bus_irq are 0.
- R2: bus_d_oe is 1 only while bus_cs_n is 0 and bus_rw is 1. It is 0 during writes and while chip select is released.
- R3: While bus_cs_n=0 and bus_rw=1, bus_d_out gives the data register when bus_rsel=0. When bus_rsel=1 it gives the status byte, which has bits 7:1 at 0 and bit 0 at HS.
- R4: A master write completed in ST_IDLE takes effect on the 3rd rising clock edge after bus_cs_n rises. At that edge rx_valid goes to 1, rx_data becomes the written byte, and HS goes to 0.
- R5: On a clock edge where rx_valid and rx_ready are both 1, rx_valid drops, tx_ready rises (the token passes to the slave), and HS stays 0.
- R6: On a clock edge where tx_valid and tx_ready are both 1, the data register loads tx_data, tx_ready drops, HS becomes 1 and bus_irq rises. This holds when IRQ_EN=1.
- R7: A master data read (bus_rsel=0) completed in ST_TXRDY returns the controller to ST_IDLE on the 3rd clock edge after bus_cs_n rises. bus_irq drops at that edge and HS stays 1.
- R8: Several accesses leave the state and the data register unchanged: any status read, a master write outside ST_IDLE, and a data read outside ST_TXRDY.
- R9: A master write with bus_rsel=1 goes to the data register exactly as one with bus_rsel=0 does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_cs_n | input | 1 | Master chip select, active low |
| bus_rw | input | 1 | 1 = master read, 0 = master write |
| bus_rsel | input | 1 | Register select (address LSB); 1 with read = status |
| bus_d_in | input | DATA_W | Bus data from the master |
| bus_d_out | output | DATA_W | Bus data toward the master |
| bus_d_oe | output | 1 | Bus driver enable |
| bus_irq | output | 1 | Interrupt request: reply byte ready |
| rx_data | output | DATA_W | Byte written by the master |
| rx_valid | output | 1 | Written byte waiting for the local side |
| rx_ready | input | 1 | Local side consumes rx_data |
| tx_data | input | DATA_W | Reply byte from the local side |
| tx_valid | input | 1 | Reply byte offered |
| tx_ready | output | 1 | Port accepts a reply byte (token with slave) |

## Verification
A master access acts through two synchronizer flops and one edge-detect stage. Its state effect is therefore due at the 3rd rising edge after bus_cs_n rises. The bench releases chip select on a falling edge, waits exactly three falling edges, and samples there. Local handshakes take effect at the first rising edge after they are driven, and the bench samples them at the next falling edge. Bus read data and output enable are combinational from the pins, so the bench checks them 1 ns after driving the pins, while chip select is still held.

// File: rtl/par_slave_pkg.sv
package par_slave_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RX     = 2'd1,
        ST_TXWAIT = 2'd2,
        ST_TXRDY  = 2'd3
    } tok_state_e;

    typedef struct packed {
        logic wr;
        logic rd_data;
    } acc_evt_t;

endpackage

// File: rtl/par_sync.sv
module par_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= RST_VAL;
        else        stg[0] <= d_async;
    end

    generate
        for (genvar i = 1; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[i] <= RST_VAL;
                else        stg[i] <= stg[i-1];
            end
        end
    endgenerate

    assign d_sync = stg[STAGES-1];
endmodule

// File: rtl/par_bus_decode.sv
module par_bus_decode
    import par_slave_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n_s,
    input  logic          rw_s,
    input  logic          rsel_s,
    input  logic [DW-1:0] d_raw,
    output acc_evt_t      evt,
    output logic [DW-1:0] wr_byte
);
    logic          cs_n_q;
    logic          lat_rw;
    logic          lat_rsel;
    logic [DW-1:0] lat_d;
    logic          trail;

    // Hold the access attributes while chip select is seen active
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n_q   <= 1'b1;
            lat_rw   <= 1'b0;
            lat_rsel <= 1'b0;
            lat_d    <= '0;
        end else begin
            cs_n_q <= cs_n_s;
            if (!cs_n_s) begin
                lat_rw   <= rw_s;
                lat_rsel <= rsel_s;
                lat_d    <= d_raw;
            end
        end
    end

    assign trail       = cs_n_s && !cs_n_q;
    assign evt.wr      = trail && !lat_rw;
    assign evt.rd_data = trail && lat_rw && !lat_rsel;
    assign wr_byte     = lat_d;
endmodule

// File: rtl/par_token_fsm.sv
module par_token_fsm
    import par_slave_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  acc_evt_t      evt,
    input  logic [DW-1:0] wr_byte,
    input  logic          rx_ready,
    input  logic          tx_valid,
    input  logic [DW-1:0] tx_data,
    output logic [DW-1:0] data_reg,
    output logic          rx_valid,
    output logic          tx_ready,
    output logic          hs_ready,
    output logic          irq_req
);
    tok_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (evt.wr)      state_nx = ST_RX;
            ST_RX:     if (rx_ready)    state_nx = ST_TXWAIT;
            ST_TXWAIT: if (tx_valid)    state_nx = ST_TXRDY;
            ST_TXRDY:  if (evt.rd_data) state_nx = ST_IDLE;
            default:                    state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            data_reg <= '0;
        else if (state == ST_IDLE && evt.wr)
            data_reg <= wr_byte;
        else if (state == ST_TXWAIT && tx_valid)
            data_reg <= tx_data;
    end

    always_comb begin
        rx_valid = 1'b0;
        tx_ready = 1'b0;
        hs_ready = 1'b0;
        irq_req  = 1'b0;
        unique case (state)
            ST_IDLE:   hs_ready = 1'b1;
            ST_RX:     rx_valid = 1'b1;
            ST_TXWAIT: tx_ready = 1'b1;
            ST_TXRDY: begin
                hs_ready = 1'b1;
                irq_req  = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/par_slave_port.sv
module par_slave_port
    import par_slave_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter bit IRQ_EN      = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_cs_n,
    input  logic              bus_rw,
    input  logic              bus_rsel,
    input  logic [DATA_W-1:0] bus_d_in,
    output logic [DATA_W-1:0] bus_d_out,
    output logic              bus_d_oe,
    output logic              bus_irq,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    input  logic              rx_ready,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready
);
    localparam int CTL_W = 3;

    logic [CTL_W-1:0] ctl_s;
    acc_evt_t         evt;
    logic [DATA_W-1:0] wr_byte;
    logic [DATA_W-1:0] data_reg;
    logic             hs_ready;
    logic             irq_req;

    par_sync #(
        .W       (CTL_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b001)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({bus_rsel, bus_rw, bus_cs_n}),
        .d_sync  (ctl_s)
    );

    par_bus_decode #(.DW(DATA_W)) u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n_s  (ctl_s[0]),
        .rw_s    (ctl_s[1]),
        .rsel_s  (ctl_s[2]),
        .d_raw   (bus_d_in),
        .evt     (evt),
        .wr_byte (wr_byte)
    );

    par_token_fsm #(.DW(DATA_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt),
        .wr_byte  (wr_byte),
        .rx_ready (rx_ready),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .data_reg (data_reg),
        .rx_valid (rx_valid),
        .tx_ready (tx_ready),
        .hs_ready (hs_ready),
        .irq_req  (irq_req)
    );

    // Read path follows the pins directly, as a bus driver would
    assign bus_d_oe  = !bus_cs_n && bus_rw;
    assign bus_d_out = bus_rsel ? {{(DATA_W-1){1'b0}}, hs_ready} : data_reg;
    assign rx_data   = data_reg;

    generate
        if (IRQ_EN) begin : g_irq
            assign bus_irq = irq_req;
        end else begin : g_noirq
            assign bus_irq = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/par_slave_port_chk.sv
module par_slave_port_chk #(
    parameter int W      = 8,
    parameter bit IRQ_EN = 1'b1
) (
    input logic         clk,
    input logic         rst_n,
    input logic         bus_cs_n,
    input logic         bus_rw,
    input logic         bus_rsel,
    input logic [W-1:0] bus_d_out,
    input logic         bus_d_oe,
    input logic         bus_irq,
    input logic [W-1:0] rx_data,
    input logic         rx_valid,
    input logic         rx_ready,
    input logic         tx_valid,
    input logic         tx_ready
);
    p_oe_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cs_n || !bus_rw) |-> !bus_d_oe);

    p_stat_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_cs_n && bus_rw && bus_rsel) |-> (bus_d_out[W-1:1] == '0));

    p_rx_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

    p_rx_to_tx_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_ready) |=> (tx_ready && !rx_valid));

    p_rx_tx_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_valid && tx_ready));

    p_tx_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> (!tx_ready && (bus_irq || !IRQ_EN)));

    p_irq_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_irq |-> (!rx_valid && !tx_ready));
endmodule

bind par_slave_port par_slave_port_chk #(.W(DATA_W), .IRQ_EN(IRQ_EN)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_cs_n  (bus_cs_n),
    .bus_rw    (bus_rw),
    .bus_rsel  (bus_rsel),
    .bus_d_out (bus_d_out),
    .bus_d_oe  (bus_d_oe),
    .bus_irq   (bus_irq),
    .rx_data   (rx_data),
    .rx_valid  (rx_valid),
    .rx_ready  (rx_ready),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready)
);

// File: tb/par_slave_port_tb_top.sv
`timescale 1ns/1ps
module par_slave_port_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_cs_n = 1'b1, bus_rw = 1'b0, bus_rsel = 1'b0;
    logic [7:0] bus_d_in = 8'h00;
    logic [7:0] bus_d_out;
    logic       bus_d_oe, bus_irq;
    logic [7:0] rx_data;
    logic       rx_valid, rx_ready = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_valid = 1'b0, tx_ready;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    par_slave_port dut_i (
        .clk(clk), .rst_n(rst_n),
        .bus_cs_n(bus_cs_n), .bus_rw(bus_rw), .bus_rsel(bus_rsel),
        .bus_d_in(bus_d_in), .bus_d_out(bus_d_out), .bus_d_oe(bus_d_oe),
        .bus_irq(bus_irq), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_ready(rx_ready), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_ready(tx_ready)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Master write; returns after the 3rd clock edge following release
    task automatic m_write(input logic [7:0] b, input logic sel);
        @(negedge clk);
        bus_cs_n = 1'b0; bus_rw = 1'b0; bus_rsel = sel; bus_d_in = b;
        #1 check(bus_d_oe == 1'b0, "R2 oe during write", bus_d_oe, 0);
        repeat (3) @(negedge clk);
        bus_cs_n = 1'b1;
        repeat (3) @(negedge clk);
        bus_d_in = 8'h00;
    endtask

    // Master read; value is sampled while chip select is held
    task automatic m_read(input logic sel, output logic [7:0] v);
        @(negedge clk);
        bus_cs_n = 1'b0; bus_rw = 1'b1; bus_rsel = sel;
        #1;
        check(bus_d_oe == 1'b1, "R2 oe during read", bus_d_oe, 1);
        v = bus_d_out;
        repeat (3) @(negedge clk);
        bus_cs_n = 1'b1; bus_rw = 1'b0;
        #1 check(bus_d_oe == 1'b0, "R2 oe after release", bus_d_oe, 0);
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        check(rx_valid == 0, "R1 rx_valid", rx_valid, 0);
        check(tx_ready == 0, "R1 tx_ready", tx_ready, 0);
        check(bus_irq == 0,  "R1 irq", bus_irq, 0);
        check(bus_d_oe == 0, "R1 oe", bus_d_oe, 0);
        m_read(1'b1, v);
        check(v == 8'h01, "R1 R3 status after reset", v, 8'h01);
        m_read(1'b0, v);
        check(v == 8'h00, "R1 data after reset", v, 8'h00);
        check(rx_valid == 0 && bus_irq == 0, "R8 idle data read no effect", {rx_valid, bus_irq}, 0);
    endtask

    // Full token round: write, consume, load reply, read reply
    task automatic t_round(input logic [7:0] wb, input logic wsel, input logic [7:0] rb, input string tag);
        logic [7:0] v;
        m_write(wb, wsel);
        check(rx_valid == 1, {tag, " rx_valid"}, rx_valid, 1);
        check(rx_data == wb, {tag, " rx_data"}, rx_data, wb);
        m_read(1'b1, v);
        check(v == 8'h00, "R4 HS busy", v, 0);
        check(rx_valid == 1, "R8 status read keeps RX", rx_valid, 1);
        m_write(wb ^ 8'hFF, 1'b0);
        check(rx_data == wb && rx_valid == 1, "R8 write in RX ignored", rx_data, wb);
        @(negedge clk) rx_ready = 1'b1;
        @(negedge clk) rx_ready = 1'b0;
        check(rx_valid == 0 && tx_ready == 1, "R5 token to slave", {rx_valid, tx_ready}, 2'b01);
        m_read(1'b1, v);
        check(v == 8'h00, "R5 HS still busy", v, 0);
        m_read(1'b0, v);
        check(tx_ready == 1 && v == wb, "R8 data read in TXWAIT", v, wb);
        m_write(8'h77, 1'b1);
        check(tx_ready == 1 && rx_data == wb, "R8 write in TXWAIT ignored", rx_data, wb);
        @(negedge clk) begin tx_valid = 1'b1; tx_data = rb; end
        @(negedge clk) begin tx_valid = 1'b0; tx_data = 8'h00; end
        check(tx_ready == 0, "R6 tx_ready drop", tx_ready, 0);
        check(bus_irq == 1, "R6 irq", bus_irq, 1);
        m_read(1'b1, v);
        check(v == 8'h01, "R6 HS ready", v, 1);
        check(bus_irq == 1, "R8 status read keeps TXRDY", bus_irq, 1);
        m_read(1'b0, v);
        check(v == rb, "R6 R3 reply data", v, rb);
        check(bus_irq == 0, "R7 irq drop", bus_irq, 0);
        m_read(1'b1, v);
        check(v == 8'h01, "R7 HS idle", v, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_round(8'hA5, 1'b0, 8'h5A, "R4");
        t_round(8'hC3, 1'b1, 8'h81, "R9");
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule